// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block is a write-only three-wire serial slave that fills a bank of sixteen 10-bit configuration registers. A host frames a transfer by pulling the active-low select low. It then clocks sixteen bits in on the data line, most significant bit first, and sets select high again. The two leading bits of a frame carry no meaning. The next four bits name the target register and the last ten bits are the value written to it.

The serial lines are oversampled by the block's own core clock through synchronizers, and edges of the serial clock are detected in that domain. A core clock at least six times the serial clock keeps up with a 40 MHz serial clock. Register 15 is the control register. Its bit 0 is a software reset that puts every register back to its default and never stays set. Its bit 1 is a power-down request that drives the standby output. The standby output can also be driven by an active-low standby pin. Writes are still accepted while standby is active. An active-low reset pin loads every register with its default.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is 16 bits sampled on rising serial-clock edges while select is low, MSB first. Frame bits 13:10 are the address and bits 9:0 are the data. The addressed register takes the data after the 16th bit, and register n appears on cfg_o[10n+9:10n].
- R2: Frame bits 15:14 are ignored; any value there gives the same write.
- R3: If select rises before the 16th bit, the partial frame is dropped, no register changes, and the next frame starts from bit count zero.
- R4: Serial-clock edges after the 16th bit in the same select-low window are ignored.
- R5: While rst_n is low, every register holds its default. Register n defaults to (69n+17) mod 1024 for n from 0 to 14, and register 15 defaults to 0.
- R6: Writing register 15 with data bit 0 set returns all sixteen registers to their defaults, so register 15 then reads 0.
- R7: standby_o is high when stby_n_i is low or when bit 1 of register 15 is set, and low otherwise.
- R8: Register writes take effect while standby_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data, MSB first |
| cs_n_i | input | 1 | Active-low frame select |
| stby_n_i | input | 1 | Active-low standby request pin |
| cfg_o | output | 160 | All registers, register n at bits 10n+9:10n |
| standby_o | output | 1 | Standby indication |

## Verification
The assertions assume the serial lines are clean, slow signals as seen from the core clock. They assume each serial-clock high or low phase lasts several core cycles, and that data is stable around every rising serial-clock edge, so one serial edge gives exactly one detected rise. The stimulus changes data only while the serial clock is low and holds each phase for 13 ns against a 4 ns core clock. It also waits well past the synchronizer latency before it moves select or checks an output.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned SCP_DW = 10;
  localparam int unsigned SCP_AW = 4;
  localparam int unsigned SCP_FRAME = 16;
  localparam int unsigned SCP_CTRL_ADDR = 15;
  localparam int unsigned SCP_SRST_BIT = 0;
  localparam int unsigned SCP_PD_BIT = 1;

  function automatic logic [SCP_DW-1:0] scp_default(input int unsigned idx);
    int unsigned v;
    if (idx == SCP_CTRL_ADDR) v = 0;
    else v = (idx * 69 + 17) % (1 << SCP_DW);
    return v[SCP_DW-1:0];
  endfunction
endpackage

// File: rtl/scp_sampler.sv
module scp_sampler #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdin_i,
  input  logic cs_n_i,
  output logic rise_o,
  output logic bit_o,
  output logic sel_o
);
  logic [SYNC-1:0] sclk_s, sdin_s, csn_s;
  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      sdin_s <= '0;
      csn_s  <= '1;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[SYNC-2:0], sclk_i};
      sdin_s <= {sdin_s[SYNC-2:0], sdin_i};
      csn_s  <= {csn_s[SYNC-2:0], cs_n_i};
      sclk_d <= sclk_s[SYNC-1];
    end
  end

  assign rise_o = sclk_s[SYNC-1] & ~sclk_d;
  assign bit_o  = sdin_s[SYNC-1];
  assign sel_o  = ~csn_s[SYNC-1];

  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/scp_frame.sv
module scp_frame #(
  parameter int unsigned FRAME = 16,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          bit_i,
  input  logic          sel_i,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned CW = $clog2(FRAME + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [FRAME-2:0] sh_q, sh_d;
  logic             wr_d;
  logic [AW-1:0]    addr_d;
  logic [DW-1:0]    data_d;
  logic [FRAME-1:0] word;
  logic             take;

  assign word = {sh_q, bit_i};
  assign take = sel_i && rise_i && (cnt_q != FULL);

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    wr_d   = 1'b0;
    addr_d = addr_o;
    data_d = data_o;
    if (!sel_i) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = word[FRAME-2:0];
      if (cnt_q == LAST) begin
        wr_d   = 1'b1;
        addr_d = word[AW+DW-1:DW];
        data_d = word[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      wr_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      wr_o   <= wr_d;
      addr_o <= addr_d;
      data_o <= data_d;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_desel_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> cnt_q == '0);
  p_wr_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> cnt_q == FULL);
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !wr_o);
endmodule

// File: rtl/scp_bank.sv
module scp_bank #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 10,
  parameter int unsigned CTRL = 15,
  parameter int unsigned SRST = 0,
  parameter int unsigned PD = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  output logic [(1<<AW)*DW-1:0] regs_o,
  output logic               pd_o
);
  import scp_pkg::*;
  localparam int unsigned NREG = 1 << AW;

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic          srst;

  assign srst = wr_i && (addr_i == AW'(CTRL)) && data_i[SRST];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      if (srst) regs_d[i] = scp_default(i);
      else if (wr_i && addr_i == AW'(i)) regs_d[i] = data_i;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[g] <= scp_default(g);
        else        regs_q[g] <= regs_d[g];
      end
      assign regs_o[g*DW +: DW] = regs_q[g];

      p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && !srst && addr_i == AW'(g) |=> regs_q[g] == $past(data_i));
      p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(regs_q[g]));
      p_soft_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> regs_q[g] == scp_default(g));
    end
  endgenerate

  assign pd_o = regs_q[CTRL][PD];
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int unsigned FRAME = scp_pkg::SCP_FRAME,
  parameter int unsigned AW    = scp_pkg::SCP_AW,
  parameter int unsigned DW    = scp_pkg::SCP_DW,
  parameter int unsigned SYNC  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_i,
  input  logic                  sdin_i,
  input  logic                  cs_n_i,
  input  logic                  stby_n_i,
  output logic [(1<<AW)*DW-1:0] cfg_o,
  output logic                  standby_o
);
  logic          rst_meta, rst_sync;
  logic          rise, sbit, sel, wr, pd;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  scp_sampler #(.SYNC(SYNC)) u_smp (
    .clk(clk), .rst_n(rst_sync), .sclk_i(sclk_i), .sdin_i(sdin_i),
    .cs_n_i(cs_n_i), .rise_o(rise), .bit_o(sbit), .sel_o(sel));

  scp_frame #(.FRAME(FRAME), .AW(AW), .DW(DW)) u_frm (
    .clk(clk), .rst_n(rst_sync), .rise_i(rise), .bit_i(sbit), .sel_i(sel),
    .wr_o(wr), .addr_o(addr), .data_o(data));

  scp_bank #(.AW(AW), .DW(DW), .CTRL(scp_pkg::SCP_CTRL_ADDR),
             .SRST(scp_pkg::SCP_SRST_BIT), .PD(scp_pkg::SCP_PD_BIT)) u_bank (
    .clk(clk), .rst_n(rst_sync), .wr_i(wr), .addr_i(addr), .data_i(data),
    .regs_o(cfg_o), .pd_o(pd));

  assign standby_o = ~stby_n_i | pd;

  p_pin_standby_r7: assert property (@(posedge clk) disable iff (!rst_sync)
    !stby_n_i |-> standby_o);
  p_no_srst_seen_r6: assert property (@(posedge clk) disable iff (!rst_sync)
    cfg_o[scp_pkg::SCP_CTRL_ADDR*DW + scp_pkg::SCP_SRST_BIT] == 1'b0);
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
  logic clk = 1'b0;
  logic rst_n, sclk, sdin, cs_n, stby_n;
  logic [159:0] cfg;
  logic standby;
  int checks = 0;
  int errors = 0;
  logic [9:0] model [16];

  serial_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .cs_n_i(cs_n),
    .stby_n_i(stby_n), .cfg_o(cfg), .standby_o(standby));

  always #2 clk = ~clk;

  function automatic logic [9:0] dflt(input int n);
    return (n == 15) ? 10'd0 : 10'((n * 69 + 17) % 1024);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) check(req, 32'(cfg[i*10 +: 10]), 32'(model[i]));
  endtask

  task automatic load_defaults();
    for (int i = 0; i < 16; i++) model[i] = dflt(i);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n, input bit raise);
    cs_n = 1'b0;
    #20;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; sdin = w[i]; #13;
      sclk = 1'b1; #13;
    end
    sclk = 1'b0;
    #20;
    if (raise) begin cs_n = 1'b1; #40; end
  endtask

  task automatic write_reg(input logic [1:0] nul, input logic [3:0] a, input logic [9:0] d);
    shift_bits({16'd0, nul, a, d}, 16, 1'b1);
    model[a] = d;
  endtask

  task automatic t_reset();
    load_defaults();
    check_all("R5 reset defaults");
    check("R7 standby idle", 32'(standby), 32'd0);
  endtask

  task automatic t_writes();
    write_reg(2'b00, 4'd3, 10'h2A5);
    write_reg(2'b00, 4'd0, 10'h3FF);
    write_reg(2'b00, 4'd14, 10'h000);
    check_all("R1 basic writes");
  endtask

  task automatic t_nulls();
    write_reg(2'b11, 4'd5, 10'h155);
    write_reg(2'b10, 4'd8, 10'h0C3);
    check_all("R2 null bits ignored");
  endtask

  task automatic t_partial();
    shift_bits({16'd0, 2'b00, 4'd5, 10'h0AA} >> 6, 10, 1'b1);
    check_all("R3 partial frame dropped");
    write_reg(2'b00, 4'd6, 10'h2D2);
    check("R3 counter restarted", 32'(cfg[60 +: 10]), 32'h2D2);
  endtask

  task automatic t_overlong();
    shift_bits({16'd0, 2'b00, 4'd7, 10'h111}, 16, 1'b0);
    shift_bits(32'h3F, 6, 1'b1);
    model[7] = 10'h111;
    check_all("R4 extra bits ignored");
  endtask

  task automatic t_standby();
    stby_n = 1'b0; #20;
    check("R7 pin standby", 32'(standby), 32'd1);
    write_reg(2'b00, 4'd9, 10'h1E1);
    check("R8 write during standby", 32'(cfg[90 +: 10]), 32'h1E1);
    stby_n = 1'b1; #20;
    check("R7 pin released", 32'(standby), 32'd0);
    write_reg(2'b00, 4'd15, 10'h002);
    check("R7 power-down bit", 32'(standby), 32'd1);
    write_reg(2'b00, 4'd2, 10'h0F0);
    check("R8 write during power-down", 32'(cfg[20 +: 10]), 32'h0F0);
    write_reg(2'b00, 4'd15, 10'h000);
    check("R7 power-down cleared", 32'(standby), 32'd0);
  endtask

  task automatic t_soft_reset();
    write_reg(2'b00, 4'd4, 10'h123);
    write_reg(2'b00, 4'd15, 10'h002);
    shift_bits({16'd0, 2'b00, 4'd15, 10'h003}, 16, 1'b1);
    load_defaults();
    check_all("R6 soft reset defaults");
    check("R6 ctrl reads zero", 32'(cfg[150 +: 10]), 32'd0);
    check("R6 standby after soft reset", 32'(standby), 32'd0);
  endtask

  task automatic t_hw_reset();
    write_reg(2'b00, 4'd1, 10'h321);
    write_reg(2'b00, 4'd15, 10'h002);
    rst_n = 1'b0; #10;
    load_defaults();
    check_all("R5 hardware reset defaults");
    #10 rst_n = 1'b1; #40;
    check_all("R5 defaults after release");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sdin = 1'b0; cs_n = 1'b1; stby_n = 1'b1;
    #21 rst_n = 1'b1;
    #40;
    t_reset();
    t_writes();
    t_nulls();
    t_partial();
    t_overlong();
    t_standby();
    t_soft_reset();
    t_hw_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule